// File: doc/BRIEF.md
# Sleep-Triggered Fast Rail Gate

This block sits next to a slow power sequencer and controls six run-state rail and handshake outputs. When the platform is running it passes the sequencer's requested output levels through one register stage. It watches two asynchronous inputs, the active-low sleep-S3 line and the active-low processor deep-idle gate. It acts on them within a few clock cycles and does not wait for the sequencer's own tick.

A falling sleep-S3 edge while the platform-on flag is high starts a fixed shutdown order. The sustain power-good output drops first. One cycle later the controller power-ok, system power-ok, core regulator enable and S0 rail enable drop together. The IO rail enable drops last, after a parameterised number of cycles, so that it falls between the minimum delay after power-ok and the maximum delay after sleep-S3. All outputs then stay off, whatever the sequencer requests, until the sequencer acknowledges suspend.

While sleep-S3 is high, gating is enabled and the platform is on, the S0 rail enable is also masked by the idle-gate input. A low gate turns the S0 rails off. The IO rail enable and the power-good outputs are not affected by this masking.

Top module: `fast_rail_gate`

## Requirements
- R1: While `rst` is high at a clock edge, all six outputs are 0 after that edge, whatever the request inputs are.
- R2: With no shutdown in progress and idle masking inactive, each output equals its `req_*` input as sampled at the previous clock edge.
- R3: When `sleep_n_i` falls with `plat_on_i` high and first reads low at edge n, `sust_pg_o` is 0 after edge n+2. The other outputs still follow their requests after that edge.
- R4: After edge n+3, `ctl_ok_o`, `sys_ok_o`, `vr_en_o` and `s0_en_o` are 0, and `io_en_o` still follows its request.
- R5: `io_en_o` drops exactly `IO_DLY_CYC` clock cycles after `ctl_ok_o` drops, at edge n+3+`IO_DLY_CYC`, and not before.
- R6: Once the shutdown has completed, all outputs stay 0 whatever the requests are. They stay 0 until `susp_ack_i` reads 1 at an edge. After that edge the outputs follow the requests again.
- R7: A falling `sleep_n_i` while `plat_on_i` is low starts no shutdown, and the outputs keep following their requests.
- R8: With `gate_en_i`, `plat_on_i` and `sleep_n_i` all high, `s0_en_o` equals `req_s0_en_i` AND the level of `idle_gate_n_i`. A change of `idle_gate_n_i` first read at edge n shows on `s0_en_o` after edge n+2.
- R9: While `sleep_n_i` is low, `idle_gate_n_i` has no effect on any output.
- R10: Idle masking changes only `s0_en_o`. `io_en_o`, `sust_pg_o` and `ctl_ok_o` keep following their requests.
- R11: While `gate_en_i` is low, `idle_gate_n_i` has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep_n_i | input | 1 | Asynchronous sleep-S3 line, low = suspend requested |
| idle_gate_n_i | input | 1 | Asynchronous deep-idle gate, low = gate S0 rails |
| gate_en_i | input | 1 | Enables idle masking of the S0 rails |
| plat_on_i | input | 1 | Platform is in the run state |
| susp_ack_i | input | 1 | Sequencer has reached suspend; releases the override |
| req_sust_pg_i | input | 1 | Sequencer request: sustain power-good |
| req_ctl_ok_i | input | 1 | Sequencer request: controller power-ok |
| req_sys_ok_i | input | 1 | Sequencer request: system power-ok |
| req_vr_en_i | input | 1 | Sequencer request: core regulator enable |
| req_s0_en_i | input | 1 | Sequencer request: S0 rail enable |
| req_io_en_i | input | 1 | Sequencer request: IO rail enable |
| sust_pg_o | output | 1 | Sustain power-good |
| ctl_ok_o | output | 1 | Controller power-ok |
| sys_ok_o | output | 1 | System power-ok |
| vr_en_o | output | 1 | Core regulator enable |
| s0_en_o | output | 1 | S0 rail enable |
| io_en_o | output | 1 | IO rail enable |

## Verification
The bench counts edges from the sleep-S3 fall and samples each output at the exact edge where it should change. If the power-good drop were late by a cycle, or merged with the power-ok group, the ordering checks would see both low at the same time. The IO rail is sampled one cycle before and at its drop edge, so an off-by-one in the delay counter shows up, and a premature release of the override shows up as outputs rising before the acknowledge. Sleep falls with the platform off, and idle-gate toggles with sleep low or gating disabled, must leave every output untouched. A design that let idle masking reach the IO or power-good outputs would fail the idle-gate test.

// File: rtl/rail_gate_pkg.sv
package rail_gate_pkg;

  typedef enum logic [1:0] {
    ST_RUN     = 2'd0,
    ST_DROP_PG = 2'd1,
    ST_SHED    = 2'd2,
    ST_HOLD    = 2'd3
  } shed_st_e;

  typedef struct packed {
    logic sust_pg;
    logic ctl_ok;
    logic sys_ok;
    logic vr_en;
    logic s0_en;
    logic io_en;
  } rail_t;

endpackage

// File: rtl/rg_sync.sv
module rg_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= {STAGES{RST_VAL}};
    else     chain_q <= {chain_q[STAGES-2:0], din};
  end

  assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/rg_shed_fsm.sv
module rg_shed_fsm
  import rail_gate_pkg::*;
#(
  parameter int IO_DLY_CYC = 128
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     trig,
  input  logic     ack,
  output shed_st_e st_q,
  output shed_st_e st_d
);
  localparam int CW = $clog2(IO_DLY_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(IO_DLY_CYC - 1);

  logic [CW-1:0] cnt_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_RUN:     if (trig) st_d = ST_DROP_PG;
      ST_DROP_PG: st_d = ST_SHED;
      ST_SHED:    if (cnt_q == LAST) st_d = ST_HOLD;
      ST_HOLD:    if (ack) st_d = ST_RUN;
      default:    st_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_RUN;
      cnt_q <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_SHED) cnt_q <= cnt_q + 1'b1;
      else                 cnt_q <= '0;
    end
  end
endmodule

// File: rtl/rg_rail_mux.sv
module rg_rail_mux
  import rail_gate_pkg::*;
(
  input  shed_st_e st_d,
  input  rail_t    req,
  input  logic     gate_act,
  input  logic     idle_lvl,
  output rail_t    nxt
);
  always_comb begin
    nxt = req;
    if (gate_act && !idle_lvl) nxt.s0_en = 1'b0;
    unique case (st_d)
      ST_DROP_PG: nxt.sust_pg = 1'b0;
      ST_SHED: begin
        nxt.sust_pg = 1'b0;
        nxt.ctl_ok  = 1'b0;
        nxt.sys_ok  = 1'b0;
        nxt.vr_en   = 1'b0;
        nxt.s0_en   = 1'b0;
      end
      ST_HOLD: nxt = '0;
      default: ;
    endcase
  end
endmodule

// File: rtl/fast_rail_gate.sv
module fast_rail_gate
  import rail_gate_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int IO_DLY_CYC  = 128
) (
  input  logic clk,
  input  logic rst,
  input  logic sleep_n_i,
  input  logic idle_gate_n_i,
  input  logic gate_en_i,
  input  logic plat_on_i,
  input  logic susp_ack_i,
  input  logic req_sust_pg_i,
  input  logic req_ctl_ok_i,
  input  logic req_sys_ok_i,
  input  logic req_vr_en_i,
  input  logic req_s0_en_i,
  input  logic req_io_en_i,
  output logic sust_pg_o,
  output logic ctl_ok_o,
  output logic sys_ok_o,
  output logic vr_en_o,
  output logic s0_en_o,
  output logic io_en_o
);
  logic     sleep_s, idle_s, sleep_prev_q, trig;
  shed_st_e st_q, st_d;
  rail_t    req, nxt, out_q;

  rg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sleep (
    .clk(clk), .rst(rst), .din(sleep_n_i), .dout(sleep_s)
  );

  rg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_idle (
    .clk(clk), .rst(rst), .din(idle_gate_n_i), .dout(idle_s)
  );

  always_ff @(posedge clk) begin
    if (rst) sleep_prev_q <= 1'b0;
    else     sleep_prev_q <= sleep_s;
  end

  assign trig = sleep_prev_q && !sleep_s && plat_on_i;

  rg_shed_fsm #(.IO_DLY_CYC(IO_DLY_CYC)) u_fsm (
    .clk(clk), .rst(rst), .trig(trig), .ack(susp_ack_i),
    .st_q(st_q), .st_d(st_d)
  );

  assign req = '{sust_pg: req_sust_pg_i, ctl_ok: req_ctl_ok_i,
                 sys_ok: req_sys_ok_i, vr_en: req_vr_en_i,
                 s0_en: req_s0_en_i, io_en: req_io_en_i};

  rg_rail_mux u_mux (
    .st_d(st_d), .req(req),
    .gate_act(gate_en_i && plat_on_i && sleep_s),
    .idle_lvl(idle_s), .nxt(nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) out_q <= '0;
    else     out_q <= nxt;
  end

  assign sust_pg_o = out_q.sust_pg;
  assign ctl_ok_o  = out_q.ctl_ok;
  assign sys_ok_o  = out_q.sys_ok;
  assign vr_en_o   = out_q.vr_en;
  assign s0_en_o   = out_q.s0_en;
  assign io_en_o   = out_q.io_en;
endmodule

// File: rtl/fast_rail_gate_chk.sv
module fast_rail_gate_chk
  import rail_gate_pkg::*;
(
  input logic     clk,
  input logic     rst,
  input shed_st_e st_q,
  input logic     trig,
  input logic     req_io_en_i,
  input logic     sust_pg_o,
  input logic     ctl_ok_o,
  input logic     sys_ok_o,
  input logic     vr_en_o,
  input logic     s0_en_o,
  input logic     io_en_o
);
  logic [5:0] outs;
  assign outs = {sust_pg_o, ctl_ok_o, sys_ok_o, vr_en_o, s0_en_o, io_en_o};

  a_r1_reset_clears: assert property (@(posedge clk) rst |=> (outs == 6'b0));

  a_r3_pg_drops_on_trigger: assert property (@(posedge clk) disable iff (rst)
    trig |=> !sust_pg_o);

  a_r4_shed_group_off: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_SHED) |-> (outs[5:1] == 5'b0));

  a_r6_hold_all_off: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_HOLD) |-> (outs == 6'b0));

  a_r10_io_follows_in_run: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && st_q == ST_RUN) |-> (io_en_o == $past(req_io_en_i)));
endmodule

bind fast_rail_gate fast_rail_gate_chk u_chk (
  .clk(clk), .rst(rst), .st_q(st_q), .trig(trig), .req_io_en_i(req_io_en_i),
  .sust_pg_o(sust_pg_o), .ctl_ok_o(ctl_ok_o), .sys_ok_o(sys_ok_o),
  .vr_en_o(vr_en_o), .s0_en_o(s0_en_o), .io_en_o(io_en_o)
);

// File: tb/fast_rail_gate_test.sv
`timescale 1ns/1ps
module fast_rail_gate_test;
  localparam int D = 128;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sleep_n = 1'b1, idle_n = 1'b1, gate_en = 1'b0, plat_on = 1'b0, ack = 1'b0;
  logic [5:0] req = 6'b111111;
  logic sust, ctl, sys, vr, s0, io;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  fast_rail_gate #(.SYNC_STAGES(2), .IO_DLY_CYC(D)) uut (
    .clk(clk), .rst(rst), .sleep_n_i(sleep_n), .idle_gate_n_i(idle_n),
    .gate_en_i(gate_en), .plat_on_i(plat_on), .susp_ack_i(ack),
    .req_sust_pg_i(req[5]), .req_ctl_ok_i(req[4]), .req_sys_ok_i(req[3]),
    .req_vr_en_i(req[2]), .req_s0_en_i(req[1]), .req_io_en_i(req[0]),
    .sust_pg_o(sust), .ctl_ok_o(ctl), .sys_ok_o(sys), .vr_en_o(vr),
    .s0_en_o(s0), .io_en_o(io)
  );

  function automatic logic [5:0] outs();
    return {sust, ctl, sys, vr, s0, io};
  endfunction

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  task automatic at_neg();
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [5:0] act, input logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic t_reset();
    tick(4);
    chk("R1 reset clears outputs", outs(), 6'b0);
    at_neg(); rst = 1'b0; plat_on = 1'b1;
    tick(4);
  endtask

  task automatic t_pass();
    at_neg(); req = 6'b111111; tick(1);
    chk("R2 pass all on", outs(), 6'b111111);
    at_neg(); req = 6'b101010; tick(1);
    chk("R2 pass pattern a", outs(), 6'b101010);
    at_neg(); req = 6'b010101; tick(1);
    chk("R2 pass pattern b", outs(), 6'b010101);
    at_neg(); req = 6'b111111; tick(1);
  endtask

  task automatic t_shutdown();
    at_neg(); sleep_n = 1'b0;
    tick(2);
    chk("R3 pg still on before trigger edge", outs(), 6'b111111);
    tick(1);
    chk("R3 pg drops first", outs(), 6'b011111);
    tick(1);
    chk("R4 power-ok group drops", outs(), 6'b000001);
    tick(D - 1);
    chk("R5 io held until delay", outs(), 6'b000001);
    tick(1);
    chk("R5 io drops after delay", outs(), 6'b000000);
    tick(5);
    chk("R6 override holds without ack", outs(), 6'b000000);
    at_neg(); ack = 1'b1; tick(1);
    chk("R6 release on ack", outs(), 6'b111111);
    at_neg(); ack = 1'b0;
    sleep_n = 1'b1; tick(4);
    chk("R2 running after release", outs(), 6'b111111);
  endtask

  task automatic t_no_plat();
    at_neg(); plat_on = 1'b0; sleep_n = 1'b0;
    tick(D + 10);
    chk("R7 no shutdown when platform off", outs(), 6'b111111);
    at_neg(); sleep_n = 1'b1; tick(4);
    at_neg(); plat_on = 1'b1; tick(2);
  endtask

  task automatic t_gating();
    at_neg(); gate_en = 1'b1; idle_n = 1'b1; tick(4);
    chk("R8 gate high keeps s0 on", outs(), 6'b111111);
    at_neg(); idle_n = 1'b0;
    tick(2);
    chk("R8 s0 unchanged before latency", outs(), 6'b111111);
    tick(1);
    chk("R8 s0 follows low gate, R10 others kept", outs(), 6'b111101);
    at_neg(); req = 6'b101111; tick(1);
    chk("R10 io and pg follow requests while gated", outs(), 6'b101101);
    at_neg(); req = 6'b111111; idle_n = 1'b1;
    tick(3);
    chk("R8 s0 back on with gate high", outs(), 6'b111111);
  endtask

  task automatic t_gate_disabled();
    at_neg(); gate_en = 1'b0; idle_n = 1'b0; tick(5);
    chk("R11 gate ignored when disabled", outs(), 6'b111111);
    at_neg(); idle_n = 1'b1; tick(4);
  endtask

  task automatic t_sleep_low();
    at_neg(); plat_on = 1'b0; sleep_n = 1'b0; tick(4);
    at_neg(); plat_on = 1'b1; gate_en = 1'b1; tick(2);
    at_neg(); idle_n = 1'b0; tick(5);
    chk("R9 gate ignored while sleep low", outs(), 6'b111111);
    at_neg(); idle_n = 1'b1; gate_en = 1'b0; tick(3);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_pass();
    t_shutdown();
    t_no_plat();
    t_gating();
    t_gate_disabled();
    t_sleep_low();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule